// File: doc/BRIEF.md
# Lockable-Victim Translation Cache

This block is a small, fully associative translation cache. Each slot maps a device address page to a physical page. A page is 4 KB, 64 KB, 1 MB or 16 MB. A lookup port returns a registered hit flag and the physical address one cycle after a request. A single command strobe selects one of five register-style operations:

- load a slot,
- read back the slot the victim pointer selects,
- invalidate every slot covering an address,
- invalidate everything,
- write the lock register.

Replacement is round-robin, driven by the victim pointer in the lock register. The same register holds a base count. Slots below the base are preserved: when the pointer runs off the end of the array it returns to the base, not to zero. A preserved load always takes the slot at the base and then raises the base by one, so the locked region grows from index zero upward. Software reads a slot by steering the victim pointer to that index with a lock write, then issuing a read.

Top module: `tlb_lockvict`

## Requirements
- R1: After reset every slot is invalid, the lock base and victim pointer are zero, and the lookup reports a miss.
- R2: A normal load (cmdOp=0, cmdPreserve=0) writes the slot at the victim pointer if that index is below the slot count. The victim pointer then increments, and when the incremented value reaches the slot count it becomes the lock base instead. An out-of-range victim writes no slot.
- R3: A preserved load (cmdOp=0, cmdPreserve=1) with base below the slot count writes the slot at index base. Base and victim pointer both become the old base plus one.
- R4: A preserved load with base equal to the slot count changes no slot and no lock field. It raises busyErr for exactly the following cycle.
- R5: A lock write (cmdOp=4) loads base from cmdBase, clamped to the slot count, and loads the victim pointer from cmdVictim.
- R6: A read (cmdOp=1) raises rdValid one cycle later with the slot at the victim pointer: its valid bit, aligned page address, page-size code and aligned physical page. An out-of-range pointer returns all zeros.
- R7: The page-size code is 0=16 MB, 1=1 MB, 2=64 KB, 3=4 KB. A slot hits when the address bits above that page's offset match. The physical address is the slot's page bits joined with the request's offset bits.
- R8: When several valid slots hit, the lowest index supplies the result.
- R9: lkHit and lkPa are registered, one cycle after lkValid. With lkValid low the following cycle shows a miss and a zero address.
- R10: A page flush (cmdOp=2) invalidates every valid slot whose page start is at or below cmdVa and whose page end lies above it. The lock fields and all other slots are unchanged.
- R11: A global flush (cmdOp=3) invalidates every slot and clears base and victim pointer to zero.
- R12: Every command takes effect at the clock edge where its strobe is sampled. A lookup in that same cycle sees the contents from before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | 0 load, 1 read, 2 page flush, 3 global flush, 4 lock write |
| cmdPreserve | input | 1 | Load goes into the preserved region |
| cmdVa | input | 32 | Page address for load, or address for page flush |
| cmdPa | input | 32 | Physical page for load |
| cmdPgSz | input | 2 | Page-size code for load |
| cmdBase | input | CNT_W | Base value for lock write |
| cmdVictim | input | CNT_W | Victim value for lock write |
| lkValid | input | 1 | Lookup request |
| lkVa | input | 32 | Lookup address |
| lkHit | output | 1 | Registered lookup hit |
| lkPa | output | 32 | Registered translated address |
| rdValid | output | 1 | Read data present |
| rdEntryValid | output | 1 | Valid bit of the slot read |
| rdVa | output | 32 | Page address of the slot read |
| rdPa | output | 32 | Physical page of the slot read |
| rdPgSz | output | 2 | Page-size code of the slot read |
| busyErr | output | 1 | Preserved load refused |
| lockBase | output | CNT_W | Current lock base |
| lockVictim | output | CNT_W | Current victim pointer |

## Verification
The hardest situation to reach is a full preserved region. In that state the base equals the slot count, the victim pointer sits out of range, and normal loads must neither write nor wander. The stimulus gets there by a global flush, then preserved loads, then a run of normal loads that carries the pointer past the end so it returns to the base. Further preserved loads then lift the base to the count, after which a refused preserved load and an idle normal load are issued. A long stretch of mixed random commands over a few overlapping pages then exercises flushes that cover several slots, and lock writes that point the reader below the base.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int ADDR_W = 32;

  typedef enum logic [2:0] {
    OP_LOAD       = 3'd0,
    OP_READ       = 3'd1,
    OP_FLUSH_PAGE = 3'd2,
    OP_FLUSH_ALL  = 3'd3,
    OP_SET_LOCK   = 3'd4
  } tlbOp_e;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic flushPage;
    logic flushAll;
  } tlbStrobe_t;

  // Offset bits for a page-size code: 0=16MB, 1=1MB, 2=64KB, 3=4KB
  function automatic logic [ADDR_W-1:0] offsetMask(input logic [1:0] sz);
    case (sz)
      2'd0:    offsetMask = ADDR_W'(32'h00FF_FFFF);
      2'd1:    offsetMask = ADDR_W'(32'h000F_FFFF);
      2'd2:    offsetMask = ADDR_W'(32'h0000_FFFF);
      default: offsetMask = ADDR_W'(32'h0000_0FFF);
    endcase
  endfunction
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic             cmdPreserve,
  input  logic [CNT_W-1:0] cmdBase,
  input  logic [CNT_W-1:0] cmdVictim,
  output tlbStrobe_t       strobe,
  output logic [CNT_W-1:0] slotIdx,
  output logic             busyErr,
  output logic [CNT_W-1:0] lockBase,
  output logic [CNT_W-1:0] lockVictim
);
  localparam logic [CNT_W-1:0] N_CNT = CNT_W'(N);
  localparam logic [CNT_W:0]   N_EXT = (CNT_W + 1)'(N);

  logic             isLoad, refuse;
  logic [CNT_W-1:0] baseNxt, victNxt;
  logic [CNT_W:0]   victInc;

  always_comb begin
    isLoad           = cmdValid && (cmdOp == OP_LOAD);
    refuse           = isLoad && cmdPreserve && (lockBase == N_CNT);
    slotIdx          = (isLoad && cmdPreserve) ? lockBase : lockVictim;
    strobe.wrEn      = isLoad && !refuse && (slotIdx < N_CNT);
    strobe.rdEn      = cmdValid && (cmdOp == OP_READ);
    strobe.flushPage = cmdValid && (cmdOp == OP_FLUSH_PAGE);
    strobe.flushAll  = cmdValid && (cmdOp == OP_FLUSH_ALL);
    victInc          = {1'b0, lockVictim} + 1'b1;
    baseNxt          = lockBase;
    victNxt          = lockVictim;
    if (strobe.flushAll) begin
      baseNxt = '0;
      victNxt = '0;
    end else if (cmdValid && (cmdOp == OP_SET_LOCK)) begin
      baseNxt = (cmdBase > N_CNT) ? N_CNT : cmdBase;
      victNxt = cmdVictim;
    end else if (isLoad && !refuse) begin
      if (cmdPreserve) begin
        baseNxt = lockBase + 1'b1;
        victNxt = lockBase + 1'b1;
      end else begin
        victNxt = (victInc >= N_EXT) ? lockBase : victInc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBase   <= '0;
      lockVictim <= '0;
      busyErr    <= 1'b0;
    end else begin
      lockBase   <= baseNxt;
      lockVictim <= victNxt;
      busyErr    <= refuse;
    end
  end

  // R1
  base_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockBase <= N_CNT);
  // R4
  refuse_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    refuse |=> busyErr && lockBase == $past(lockBase) && lockVictim == $past(lockVictim));
  // R3
  preserve_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isLoad && cmdPreserve && !refuse) |=> lockBase == $past(lockBase) + 1'b1);
  // R11
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_FLUSH_ALL) |=> lockBase == '0 && lockVictim == '0);
  // R2
  wrap_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isLoad && !cmdPreserve && lockVictim == N_CNT - 1'b1) |=> lockVictim == $past(lockBase));
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strobe,
  input  logic [CNT_W-1:0]  slotIdx,
  input  logic [ADDR_W-1:0] cmdVa,
  input  logic [ADDR_W-1:0] cmdPa,
  input  logic [1:0]        cmdPgSz,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkVa,
  output logic              lkHit,
  output logic [ADDR_W-1:0] lkPa,
  output logic              rdValid,
  output logic              rdEntryValid,
  output logic [ADDR_W-1:0] rdVa,
  output logic [ADDR_W-1:0] rdPa,
  output logic [1:0]        rdPgSz
);
  logic [N-1:0]      entValid;
  logic [ADDR_W-1:0] entVa [N];
  logic [ADDR_W-1:0] entPa [N];
  logic [1:0]        entSz [N];
  logic [ADDR_W-1:0] offM  [N];
  logic [N-1:0]      lkMatch, flMatch;

  for (genvar g = 0; g < N; g++) begin : gSlot
    assign offM[g]    = offsetMask(entSz[g]);
    assign lkMatch[g] = entValid[g] && (((lkVa ^ entVa[g]) & ~offM[g]) == '0);
    assign flMatch[g] = entValid[g] && (((cmdVa ^ entVa[g]) & ~offM[g]) == '0);
  end

  logic [ADDR_W-1:0] newMask;
  assign newMask = offsetMask(cmdPgSz);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      for (int i = 0; i < N; i++) begin
        entVa[i] <= '0;
        entPa[i] <= '0;
        entSz[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (strobe.flushAll || (strobe.flushPage && flMatch[i])) entValid[i] <= 1'b0;
        if (strobe.wrEn && slotIdx == CNT_W'(i)) begin
          entValid[i] <= 1'b1;
          entVa[i]    <= cmdVa & ~newMask;
          entPa[i]    <= cmdPa & ~newMask;
          entSz[i]    <= cmdPgSz;
        end
      end
    end
  end

  logic              hitAny;
  logic [ADDR_W-1:0] hitPa;
  logic              selOk, selValid;
  logic [ADDR_W-1:0] selVa, selPa;
  logic [1:0]        selSz;

  always_comb begin
    hitAny = 1'b0;
    hitPa  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lkValid && lkMatch[i]) begin
        hitAny = 1'b1;
        hitPa  = (entPa[i] & ~offM[i]) | (lkVa & offM[i]);
      end
    end
    selOk = 1'b0; selValid = 1'b0; selVa = '0; selPa = '0; selSz = '0;
    for (int i = 0; i < N; i++) begin
      if (slotIdx == CNT_W'(i)) begin
        selOk    = 1'b1;
        selValid = entValid[i];
        selVa    = entVa[i];
        selPa    = entPa[i];
        selSz    = entSz[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lkHit <= 1'b0; lkPa <= '0;
      rdValid <= 1'b0; rdEntryValid <= 1'b0;
      rdVa <= '0; rdPa <= '0; rdPgSz <= '0;
    end else begin
      lkHit        <= hitAny;
      lkPa         <= hitPa;
      rdValid      <= strobe.rdEn;
      rdEntryValid <= strobe.rdEn && selOk && selValid;
      rdVa         <= (strobe.rdEn && selOk) ? selVa : '0;
      rdPa         <= (strobe.rdEn && selOk) ? selPa : '0;
      rdPgSz       <= (strobe.rdEn && selOk) ? selSz : '0;
    end
  end

  // R11
  flushall_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushAll |=> entValid == '0);
  // R10
  flushpage_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flushPage && !strobe.wrEn) |=> (entValid & $past(flMatch)) == '0);
  // R9
  lk_registered_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> $past(lkValid));
  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |=> rdValid);
endmodule

// File: rtl/tlb_lockvict.sv
module tlb_lockvict
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic             cmdPreserve,
  input  logic [31:0]      cmdVa,
  input  logic [31:0]      cmdPa,
  input  logic [1:0]       cmdPgSz,
  input  logic [CNT_W-1:0] cmdBase,
  input  logic [CNT_W-1:0] cmdVictim,
  input  logic             lkValid,
  input  logic [31:0]      lkVa,
  output logic             lkHit,
  output logic [31:0]      lkPa,
  output logic             rdValid,
  output logic             rdEntryValid,
  output logic [31:0]      rdVa,
  output logic [31:0]      rdPa,
  output logic [1:0]       rdPgSz,
  output logic             busyErr,
  output logic [CNT_W-1:0] lockBase,
  output logic [CNT_W-1:0] lockVictim
);
  tlbStrobe_t       strobe;
  logic [CNT_W-1:0] slotIdx;

  tlb_ctrl #(.N(NUM_ENTRIES), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPreserve(cmdPreserve), .cmdBase(cmdBase), .cmdVictim(cmdVictim),
    .strobe(strobe), .slotIdx(slotIdx), .busyErr(busyErr),
    .lockBase(lockBase), .lockVictim(lockVictim)
  );

  tlb_datapath #(.N(NUM_ENTRIES), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotIdx(slotIdx),
    .cmdVa(cmdVa), .cmdPa(cmdPa), .cmdPgSz(cmdPgSz),
    .lkValid(lkValid), .lkVa(lkVa), .lkHit(lkHit), .lkPa(lkPa),
    .rdValid(rdValid), .rdEntryValid(rdEntryValid), .rdVa(rdVa),
    .rdPa(rdPa), .rdPgSz(rdPgSz)
  );
endmodule

// File: tb/tb_tlb_lockvict.sv
`timescale 1ns/1ps
module tb_tlb_lockvict;
  localparam int N = 8;
  localparam int CW = 4;
  localparam logic [2:0] LOAD = 3'd0, READ = 3'd1, FPAGE = 3'd2, FALL = 3'd3, SETL = 3'd4;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 0, cmdPreserve = 0, lkValid = 0;
  logic [2:0] cmdOp = 0;
  logic [31:0] cmdVa = 0, cmdPa = 0, lkVa = 0;
  logic [1:0] cmdPgSz = 0;
  logic [CW-1:0] cmdBase = 0, cmdVictim = 0;
  logic lkHit, rdValid, rdEntryValid, busyErr;
  logic [31:0] lkPa, rdVa, rdPa;
  logic [1:0] rdPgSz;
  logic [CW-1:0] lockBase, lockVictim;

  always #4 clk = ~clk;

  tlb_lockvict #(.NUM_ENTRIES(N)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPreserve(cmdPreserve), .cmdVa(cmdVa), .cmdPa(cmdPa), .cmdPgSz(cmdPgSz),
    .cmdBase(cmdBase), .cmdVictim(cmdVictim), .lkValid(lkValid), .lkVa(lkVa),
    .lkHit(lkHit), .lkPa(lkPa), .rdValid(rdValid), .rdEntryValid(rdEntryValid),
    .rdVa(rdVa), .rdPa(rdPa), .rdPgSz(rdPgSz), .busyErr(busyErr),
    .lockBase(lockBase), .lockVictim(lockVictim)
  );

  int nChecks = 0, nFail = 0;
  bit mV[N];
  longint mVa[N], mPa[N];
  int mSz[N];
  int mBase = 0, mVict = 0;
  bit eHit, eRdV, eRdEV, eBusy;
  longint ePa, eRdVa, eRdPa;
  int eRdSz;

  function automatic longint pageBytes(int sz);
    case (sz)
      0: return 64'h100_0000;
      1: return 64'h10_0000;
      2: return 64'h1_0000;
      default: return 64'h1000;
    endcase
  endfunction

  task automatic cmp(string req, string what, longint act, longint exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    longint a, pb;
    int idx;
    // lookup sees the contents before this edge's command
    eHit = 0; ePa = 0;
    if (lkValid) begin
      a = longint'(lkVa);
      for (int i = N - 1; i >= 0; i--) begin
        pb = pageBytes(mSz[i]);
        if (mV[i] && a >= mVa[i] && a < mVa[i] + pb) begin
          eHit = 1; ePa = mPa[i] + (a - mVa[i]);
        end
      end
    end
    eRdV = 0; eRdEV = 0; eRdVa = 0; eRdPa = 0; eRdSz = 0; eBusy = 0;
    if (cmdValid) begin
      case (cmdOp)
        LOAD: begin
          pb = pageBytes(int'(cmdPgSz));
          if (cmdPreserve) begin
            if (mBase == N) eBusy = 1;
            else begin
              idx = mBase;
              mV[idx] = 1; mSz[idx] = int'(cmdPgSz);
              mVa[idx] = longint'(cmdVa) / pb * pb; mPa[idx] = longint'(cmdPa) / pb * pb;
              mBase++; mVict = mBase;
            end
          end else begin
            idx = mVict;
            if (idx < N) begin
              mV[idx] = 1; mSz[idx] = int'(cmdPgSz);
              mVa[idx] = longint'(cmdVa) / pb * pb; mPa[idx] = longint'(cmdPa) / pb * pb;
            end
            mVict = (mVict + 1 >= N) ? mBase : mVict + 1;
          end
        end
        READ: begin
          eRdV = 1;
          if (mVict < N) begin
            eRdEV = mV[mVict]; eRdVa = mVa[mVict]; eRdPa = mPa[mVict]; eRdSz = mSz[mVict];
          end
        end
        FPAGE: begin
          a = longint'(cmdVa);
          for (int i = 0; i < N; i++)
            if (mV[i] && mVa[i] <= a && a < mVa[i] + pageBytes(mSz[i])) mV[i] = 0;
        end
        FALL: begin
          for (int i = 0; i < N; i++) mV[i] = 0;
          mBase = 0; mVict = 0;
        end
        SETL: begin
          mBase = (int'(cmdBase) > N) ? N : int'(cmdBase);
          mVict = int'(cmdVictim);
        end
        default: ;
      endcase
    end
    @(posedge clk); #2;
    cmp("R7 R8 R9 R12", "lkHit", longint'(lkHit), longint'(eHit));
    cmp("R7 R8 R9 R12", "lkPa", longint'(lkPa), ePa);
    cmp("R4", "busyErr", longint'(busyErr), longint'(eBusy));
    cmp("R2 R3 R5 R11", "lockBase", longint'(lockBase), longint'(mBase));
    cmp("R2 R3 R5 R11", "lockVictim", longint'(lockVictim), longint'(mVict));
    cmp("R6", "rdValid", longint'(rdValid), longint'(eRdV));
    if (eRdV) begin
      cmp("R6 R10", "rdEntryValid", longint'(rdEntryValid), longint'(eRdEV));
      cmp("R6", "rdVa", longint'(rdVa), eRdVa);
      cmp("R6", "rdPa", longint'(rdPa), eRdPa);
      cmp("R6", "rdPgSz", longint'(rdPgSz), longint'(eRdSz));
    end
  endtask

  task automatic idle();
    cmdValid = 0; lkValid = 0; cycle();
  endtask
  task automatic doLoad(logic [31:0] va, logic [31:0] pa, logic [1:0] sz, bit pres);
    cmdValid = 1; cmdOp = LOAD; cmdVa = va; cmdPa = pa; cmdPgSz = sz; cmdPreserve = pres;
    cycle(); cmdValid = 0; lkValid = 0;
  endtask
  task automatic doLook(logic [31:0] va);
    lkValid = 1; lkVa = va; cycle(); lkValid = 0;
  endtask
  task automatic doCmd(logic [2:0] op, logic [31:0] va);
    cmdValid = 1; cmdOp = op; cmdVa = va; cycle(); cmdValid = 0;
  endtask
  task automatic setLock(int b, int v);
    cmdValid = 1; cmdOp = SETL; cmdBase = CW'(b); cmdVictim = CW'(v); cycle(); cmdValid = 0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(8ns * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < N; i++) begin mV[i] = 0; mVa[i] = 0; mPa[i] = 0; mSz[i] = 0; end
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    cmp("R1", "reset lockBase", longint'(lockBase), 0);
    cmp("R1", "reset lockVictim", longint'(lockVictim), 0);
    cmp("R1", "reset lkHit", longint'(lkHit), 0);
    doLook(32'h1000_3000);
    cmp("R1", "lookup after reset", longint'(lkHit), 0);

    // R7 one slot of each page size
    doLoad(32'h1000_3000, 32'hA000_0000, 2'd3, 0);
    doLoad(32'h2001_2345, 32'hB000_0000, 2'd2, 0);
    doLoad(32'h3012_3456, 32'hC000_0000, 2'd1, 0);
    doLoad(32'h45AB_CDEF, 32'hD000_0000, 2'd0, 0);
    doLook(32'h2001_F00F);
    cmp("R7", "64KB translate", longint'(lkPa), 64'hB000_F00F);
    doLook(32'h1000_3ABC);
    cmp("R7", "4KB translate", longint'(lkPa), 64'hA000_0ABC);
    doLook(32'h1000_4000);
    cmp("R7", "4KB page end miss", longint'(lkHit), 0);
    doLook(32'h301F_FFFF);
    doLook(32'h4500_0001);
    idle();

    // R8 overlapping slot at higher index loses
    doLoad(32'h45AB_C000, 32'hE000_0000, 2'd3, 0);
    doLook(32'h45AB_CDEF);
    cmp("R8", "lowest index wins", longint'(lkPa), 64'hD0AB_CDEF);

    // R10 page flush inside the 64KB page, and just past the 4KB page
    doCmd(FPAGE, 32'h2001_8000);
    doLook(32'h2001_2345);
    cmp("R10", "flushed page misses", longint'(lkHit), 0);
    doCmd(FPAGE, 32'h1000_4000);
    doLook(32'h1000_3FFF);
    cmp("R10", "neighbour page kept", longint'(lkHit), 1);
    doCmd(FPAGE, 32'h45AB_CFFF);
    doLook(32'h45AB_C000);
    cmp("R10", "all covering slots cleared", longint'(lkHit), 0);

    // R6 read back through the victim pointer
    setLock(0, 1);
    doCmd(READ, 0);
    cmp("R6", "read flushed slot", longint'(rdEntryValid), 0);
    setLock(0, 2);
    doCmd(READ, 0);
    cmp("R6", "read 1MB slot va", longint'(rdVa), 64'h3010_0000);
    setLock(15, 12);
    cmp("R5", "base clamped", longint'(lockBase), N);
    doCmd(READ, 0);
    cmp("R6", "out of range read", longint'(rdVa), 0);

    // R12 lookup in the load cycle sees the old contents
    setLock(0, 5);
    cmdValid = 1; cmdOp = LOAD; cmdVa = 32'h5000_0000; cmdPa = 32'h6000_0000;
    cmdPgSz = 2'd3; cmdPreserve = 0; lkValid = 1; lkVa = 32'h5000_0010;
    cycle(); cmdValid = 0;
    cmp("R12", "same-cycle lookup miss", longint'(lkHit), 0);
    doLook(32'h5000_0010);
    cmp("R12", "next lookup hit", longint'(lkPa), 64'h6000_0010);

    // R3 preserved loads, then R2 wrap of the victim to the base
    doCmd(FALL, 0);
    cmp("R11", "flush all base", longint'(lockBase), 0);
    doLook(32'h5000_0010);
    cmp("R11", "flush all miss", longint'(lkHit), 0);
    doLoad(32'h7000_0000, 32'h0100_0000, 2'd1, 1);
    doLoad(32'h7100_0000, 32'h0200_0000, 2'd1, 1);
    cmp("R3", "base after two", longint'(lockBase), 2);
    for (int i = 0; i < 6; i++) doLoad(32'h8000_0000 + 32'(i) * 32'h1000, 32'h9000_0000, 2'd3, 0);
    cmp("R2", "victim wrapped to base", longint'(lockVictim), 2);
    doLoad(32'h8800_0000, 32'h9100_0000, 2'd3, 0);
    doLook(32'h7000_0123);
    cmp("R2", "preserved slot kept", longint'(lkPa), 64'h0100_0123);

    // R4 fill the preserved region, then one too many
    for (int i = 0; i < 6; i++) doLoad(32'hA000_0000 + 32'(i) * 32'h10_0000, 32'h0300_0000, 2'd1, 1);
    cmp("R3", "base full", longint'(lockBase), N);
    doLoad(32'hBB00_0000, 32'h0400_0000, 2'd1, 1);
    cmp("R4", "busy raised", longint'(busyErr), 1);
    idle();
    cmp("R4", "busy one cycle", longint'(busyErr), 0);
    doLoad(32'hBC00_0000, 32'h0500_0000, 2'd1, 0);
    doLook(32'hBC00_0000);
    cmp("R2", "no write when all locked", longint'(lkHit), 0);
    doCmd(FALL, 0);

    // mixed random commands on overlapping pages
    for (int k = 0; k < 1500; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      cmdValid = (r < 70);
      cmdOp = (r < 30) ? LOAD : (r < 42) ? READ : (r < 54) ? FPAGE : (r < 57) ? FALL : SETL;
      cmdPreserve = ($urandom_range(0, 4) == 0);
      cmdVa = 32'h4000_0000 | ($urandom & 32'h0103_3FFF);
      cmdPa = $urandom;
      cmdPgSz = 2'($urandom_range(0, 3));
      cmdBase = CW'($urandom_range(0, N));
      cmdVictim = CW'($urandom_range(0, N - 1));
      lkValid = ($urandom_range(0, 3) != 0);
      lkVa = 32'h4000_0000 | ($urandom & 32'h0103_3FFF);
      cycle();
    end
    cmdValid = 0; lkValid = 0;
    idle();
    finishRun();
  end
endmodule